// File: doc/BRIEF.md
# Display panel power sequencer

This block raises and lowers the three enables of a display panel in a fixed order. The enables are the panel supply, the panel control lines and the panel data lines. Software first writes the step delays and an interface-enable bit into three setup words. Each setup word can be written only once after reset, so the delays cannot change later. Software then drives a single start bit in a control word. Setting the bit begins power-up. Clearing it begins power-down.

Every delay is a count of prescaled ticks, with `PRESCALE` clock cycles to a tick. A value of zero counts as one tick. After power-down, a rest interval of its own length must pass before another power-up can begin. A start request that arrives earlier is held until the rest interval ends. If the start bit is cleared while the panel is still powering up, the step in progress runs to its end. The panel then powers down from the level it has reached. The phase of the sequencer appears on an output port and can also be read back through the control word.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, all three gate outputs are low, the phase is off (code 0), and all four words read back as zero.
- R2: The setup words use these layouts. Word 0 holds the supply-to-control delay in [15:0] and the control-to-data delay in [31:16]. Word 1 holds the data-drop-to-control-drop delay in [15:0] and the control-drop-to-supply-drop delay in [31:16]. Word 2 holds the rest interval in [15:0] and the interface-enable bit in bit 16. Reading a setup word returns the value it accepted.
- R3: Each setup word accepts only its first write after reset. Every later write to that word leaves its readback value and its effect unchanged.
- R4: While the interface-enable bit is 0, setting the start bit leaves all gates low and the phase at off.
- R5: The control word is address 3. Its bit 0 is the start bit. A read of address 3 returns the start bit in bit 0 and the phase in [6:4]. The phase codes are 0 off, 1 powering up, 2 on, 3 powering down and 4 rest. The same code drives the `phase` port.
- R6: When the start bit is set from the off phase with the interface enabled, the supply gate rises one cycle after the write. The control gate rises N1·PRESCALE cycles after the supply gate. The data gate rises N2·PRESCALE cycles after the control gate, and the phase becomes on. N is the programmed delay, or 1 when the delay is 0.
- R7: When the start bit is cleared in the on phase, the data gate falls one cycle after the write. The control gate falls N3·PRESCALE cycles later, and the supply gate falls N4·PRESCALE cycles after that. The phase then stays at rest for N5·PRESCALE cycles and returns to off.
- R8: A programmed delay of 0 lasts exactly one tick (PRESCALE cycles).
- R9: If the start bit is cleared during power-up, the current step completes and the next gate does not rise. Power-down then continues from the current level. With the control gate on, the control gate falls after N3 ticks and the supply gate N4 ticks later. With only the supply gate on, the supply gate falls after N4 ticks.
- R10: If the start bit is set during power-down or rest, no gate rises before the rest interval ends. Power-up then begins one cycle after the phase returns to off.
- R11: The data gate is high only while the control gate is high, and the control gate is high only while the supply gate is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the word at reg_addr |
| reg_addr | input | 2 | Word address: 0..2 setup, 3 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the word at reg_addr (combinational) |
| phase | output | 3 | Current phase code |
| gate_supply | output | 1 | Panel supply enable |
| gate_ctrl | output | 1 | Panel control-line enable |
| gate_data | output | 1 | Panel data-line enable |

## Verification
The assertions assume at most one register write per cycle, with the write address always one of the four defined words. The write-once property also depends on reset being the only way a setup word unlocks. The bench drives every write for a single cycle, away from the clock edge, and never re-asserts reset mid-run. This keeps the stimulus inside those assumptions. Abort and early-restart requests are placed at known offsets inside each step. This exercises both power-down entry levels and a start request held through the rest interval.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;
    localparam int DLY_W     = 16;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 2;
    localparam int NUM_SETUP = 3;
    localparam int EN_BIT    = 16;
    localparam int PH_LSB    = 4;

    localparam logic [ADDR_W-1:0] A_UPGAP = 2'd0;
    localparam logic [ADDR_W-1:0] A_DNGAP = 2'd1;
    localparam logic [ADDR_W-1:0] A_REST  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd3;

    typedef enum logic [2:0] {
        PH_OFF   = 3'd0,
        PH_UP    = 3'd1,
        PH_ON    = 3'd2,
        PH_DOWN  = 3'd3,
        PH_RECOV = 3'd4
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP_SUP,
        ST_RAMP_CTL,
        ST_LIVE,
        ST_DROP_DAT,
        ST_DROP_CTL,
        ST_REST
    } seq_st_e;

    typedef struct packed {
        logic             en;
        logic [DLY_W-1:0] sup_to_ctl;
        logic [DLY_W-1:0] ctl_to_dat;
        logic [DLY_W-1:0] dat_to_ctl;
        logic [DLY_W-1:0] ctl_to_sup;
        logic [DLY_W-1:0] rest;
    } setup_t;

    typedef struct packed {
        logic sup;
        logic ctl;
        logic dat;
    } gates_t;

    function automatic logic [DLY_W-1:0] ticks_of(input logic [DLY_W-1:0] v);
        return (v == '0) ? DLY_W'(1) : v;
    endfunction

    function automatic phase_e phase_of(input seq_st_e s);
        case (s)
            ST_RAMP_SUP, ST_RAMP_CTL: return PH_UP;
            ST_LIVE:                  return PH_ON;
            ST_DROP_DAT, ST_DROP_CTL: return PH_DOWN;
            ST_REST:                  return PH_RECOV;
            default:                  return PH_OFF;
        endcase
    endfunction

    function automatic gates_t gates_of(input seq_st_e s);
        gates_t g;
        g.sup = (s == ST_RAMP_SUP) || (s == ST_RAMP_CTL) || (s == ST_LIVE)
             || (s == ST_DROP_DAT) || (s == ST_DROP_CTL);
        g.ctl = (s == ST_RAMP_CTL) || (s == ST_LIVE) || (s == ST_DROP_DAT);
        g.dat = (s == ST_LIVE);
        return g;
    endfunction
endpackage

// File: rtl/pps_regs.sv
`timescale 1ns/1ps
module pps_regs
    import pps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  phase_e            phase,
    output setup_t            setup,
    output logic              start,
    output logic [NUM_SETUP-1:0] locked,
    output logic [REG_W-1:0]  rdata
);
    logic [REG_W-1:0] word_q [NUM_SETUP];
    logic [NUM_SETUP-1:0] lock_q;
    logic start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SETUP; i++) begin
                word_q[i] <= '0;
            end
            lock_q  <= '0;
            start_q <= 1'b0;
        end else if (wr) begin
            for (int i = 0; i < NUM_SETUP; i++) begin
                if (addr == ADDR_W'(i) && !lock_q[i]) begin
                    word_q[i] <= wdata;
                    lock_q[i] <= 1'b1;
                end
            end
            if (addr == A_CTRL) begin
                start_q <= wdata[0];
            end
        end
    end

    always_comb begin
        setup.sup_to_ctl = word_q[0][DLY_W-1:0];
        setup.ctl_to_dat = word_q[0][16 +: DLY_W];
        setup.dat_to_ctl = word_q[1][DLY_W-1:0];
        setup.ctl_to_sup = word_q[1][16 +: DLY_W];
        setup.rest       = word_q[2][DLY_W-1:0];
        setup.en         = word_q[2][EN_BIT];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_UPGAP: rdata = word_q[0];
            A_DNGAP: rdata = word_q[1];
            A_REST:  rdata = word_q[2];
            default: begin
                rdata[0]             = start_q;
                rdata[PH_LSB +: 3]   = phase;
            end
        endcase
    end

    assign start  = start_q;
    assign locked = lock_q;
endmodule

// File: rtl/pps_timer.sv
`timescale 1ns/1ps
module pps_timer
    import pps_pkg::*;
#(
    parameter int PRESCALE = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_ticks,
    output logic             done
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    logic [PW-1:0]    pre_q;
    logic [DLY_W-1:0] rem_q;
    logic             wrap;

    assign wrap = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            pre_q <= '0;
            rem_q <= ticks_of(load_ticks);
        end else if (rem_q != '0) begin
            if (wrap) begin
                pre_q <= '0;
                rem_q <= rem_q - DLY_W'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end

    assign done = wrap && (rem_q == DLY_W'(1));
endmodule

// File: rtl/pps_fsm.sv
`timescale 1ns/1ps
module pps_fsm
    import pps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  setup_t           setup,
    input  logic             start,
    input  logic             done,
    output logic             load,
    output logic [DLY_W-1:0] load_ticks,
    output seq_st_e          state
);
    seq_st_e st_q, st_d;

    always_comb begin
        st_d       = st_q;
        load       = 1'b0;
        load_ticks = '0;
        case (st_q)
            ST_IDLE: if (start && setup.en) begin
                st_d = ST_RAMP_SUP; load = 1'b1; load_ticks = setup.sup_to_ctl;
            end
            ST_RAMP_SUP: if (done) begin
                load = 1'b1;
                if (start) begin
                    st_d = ST_RAMP_CTL; load_ticks = setup.ctl_to_dat;
                end else begin
                    st_d = ST_DROP_CTL; load_ticks = setup.ctl_to_sup;
                end
            end
            ST_RAMP_CTL: if (done) begin
                if (start) begin
                    st_d = ST_LIVE;
                end else begin
                    st_d = ST_DROP_DAT; load = 1'b1; load_ticks = setup.dat_to_ctl;
                end
            end
            ST_LIVE: if (!start) begin
                st_d = ST_DROP_DAT; load = 1'b1; load_ticks = setup.dat_to_ctl;
            end
            ST_DROP_DAT: if (done) begin
                st_d = ST_DROP_CTL; load = 1'b1; load_ticks = setup.ctl_to_sup;
            end
            ST_DROP_CTL: if (done) begin
                st_d = ST_REST; load = 1'b1; load_ticks = setup.rest;
            end
            ST_REST: if (done) begin
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/panel_pwr_seq.sv
`timescale 1ns/1ps
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int PRESCALE = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [2:0]        phase,
    output logic              gate_supply,
    output logic              gate_ctrl,
    output logic              gate_data
);
    setup_t               setup;
    logic                 start;
    logic [NUM_SETUP-1:0] locked;
    seq_st_e              state;
    logic                 tmr_load;
    logic [DLY_W-1:0]     tmr_ticks;
    logic                 tmr_done;
    phase_e               ph;
    gates_t               gates;

    pps_regs regs_i (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .phase(ph), .setup(setup), .start(start), .locked(locked), .rdata(reg_rdata)
    );

    pps_timer #(.PRESCALE(PRESCALE)) timer_i (
        .clk(clk), .rst(rst), .load(tmr_load), .load_ticks(tmr_ticks), .done(tmr_done)
    );

    pps_fsm fsm_i (
        .clk(clk), .rst(rst), .setup(setup), .start(start), .done(tmr_done),
        .load(tmr_load), .load_ticks(tmr_ticks), .state(state)
    );

    assign ph          = phase_of(state);
    assign gates       = gates_of(state);
    assign phase       = ph;
    assign gate_supply = gates.sup;
    assign gate_ctrl   = gates.ctl;
    assign gate_data   = gates.dat;
endmodule

// File: rtl/pps_checker.sv
`timescale 1ns/1ps
module pps_checker
    import pps_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [2:0]           phase,
    input logic                 gate_supply,
    input logic                 gate_ctrl,
    input logic                 gate_data,
    input logic                 if_en,
    input logic [NUM_SETUP-1:0] locked,
    input setup_t               setup
);
    assert_reset_off_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!gate_supply && !gate_ctrl && !gate_data && phase == PH_OFF));

    assert_locked_word_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr != A_CTRL && locked[reg_addr]) |=> $stable(setup));

    assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OFF && !if_en) |=> !gate_supply);

    assert_phase_code_R5: assert property (@(posedge clk) disable iff (rst)
        phase <= PH_RECOV);

    assert_supply_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_supply) |-> ($past(phase) == PH_OFF && phase == PH_UP));

    assert_supply_last_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_supply) |-> (phase == PH_RECOV && !gate_ctrl && !gate_data));

    assert_rest_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RECOV) |=> ((phase == PH_RECOV || phase == PH_OFF) && !gate_supply));

    assert_data_nest_R11: assert property (@(posedge clk) disable iff (rst)
        gate_data |-> gate_ctrl);

    assert_ctrl_nest_R11: assert property (@(posedge clk) disable iff (rst)
        gate_ctrl |-> gate_supply);
endmodule

bind panel_pwr_seq pps_checker chk_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .phase(phase),
    .gate_supply(gate_supply), .gate_ctrl(gate_ctrl), .gate_data(gate_data),
    .if_en(setup.en), .locked(locked), .setup(setup)
);

// File: tb/panel_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module panel_pwr_seq_tb_top;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  phase;
    logic        gs, gc, gd;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    panel_pwr_seq #(.PRESCALE(P)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .phase(phase), .gate_supply(gs), .gate_ctrl(gc), .gate_data(gd)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: mode uses phase codes, lvl = number of gates on
    int          m_mode = 0, m_lvl = 0, m_left = 0;
    bit          m_start = 0;
    logic [31:0] m_w [3];
    bit          m_lk [3];

    function automatic int eff(input logic [15:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_lvl = 0; m_left = 0; m_start = 0;
            for (int i = 0; i < 3; i++) begin m_w[i] = '0; m_lk[i] = 0; end
        end else begin
            case (m_mode)
                0: if (m_start && m_w[2][16]) begin
                    m_mode = 1; m_lvl = 1; m_left = eff(m_w[0][15:0]) * P;
                end
                1: if (m_left > 1) m_left--;
                   else if (m_start) begin
                       if (m_lvl == 1) begin m_lvl = 2; m_left = eff(m_w[0][31:16]) * P; end
                       else begin m_lvl = 3; m_mode = 2; end
                   end else begin
                       m_mode = 3;
                       m_left = (m_lvl == 2) ? eff(m_w[1][15:0]) * P : eff(m_w[1][31:16]) * P;
                   end
                2: if (!m_start) begin m_mode = 3; m_lvl = 2; m_left = eff(m_w[1][15:0]) * P; end
                3: if (m_left > 1) m_left--;
                   else if (m_lvl == 2) begin m_lvl = 1; m_left = eff(m_w[1][31:16]) * P; end
                   else begin m_lvl = 0; m_mode = 4; m_left = eff(m_w[2][15:0]) * P; end
                default: if (m_left > 1) m_left--; else m_mode = 0;
            endcase
            if (wr) begin
                if (addr == 2'd3) m_start = wdata[0];
                else if (!m_lk[addr]) begin m_w[addr] = wdata; m_lk[addr] = 1; end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R6 supply gate vs model", gs, m_lvl >= 1);
            check("R7 control gate vs model", gc, m_lvl >= 2);
            check("R11 data gate vs model", gd, m_lvl >= 3);
            check("R5 phase vs model", phase, m_mode);
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end

    initial begin
        logic [31:0] d;
        int cnt;
        bit leak;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check("R1 gates off", {gs, gc, gd}, 0);
        check("R1 phase off", phase, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 word zero", d, 0);
        end
        @(negedge clk);

        // R4 start ignored while interface disabled
        wr_reg(2'd3, 32'd1);
        repeat (12) @(negedge clk);
        check("R4 supply stays low", gs, 0);
        check("R4 phase stays off", phase, 0);
        wr_reg(2'd3, 32'd0);

        // R2 setup, R3 write-once
        wr_reg(2'd0, {16'd3, 16'd2});
        wr_reg(2'd1, {16'd0, 16'd2});
        wr_reg(2'd2, 32'h0001_0005);
        wr_reg(2'd0, 32'hABCD_1234);
        wr_reg(2'd2, 32'h0000_0000);
        rd(2'd0, d); check("R3 word0 kept", d, 32'h0003_0002);
        rd(2'd1, d); check("R2 word1 readback", d, 32'h0000_0002);
        rd(2'd2, d); check("R3 word2 kept", d, 32'h0001_0005);
        @(negedge clk);

        // R6 power-up order and spacing
        wr_reg(2'd3, 32'd1);
        @(negedge clk);
        check("R6 supply up first", gs, 1);
        check("R6 control still low", gc, 0);
        check("R6 phase up", phase, 1);
        repeat (7) @(negedge clk);
        check("R6 control before gap end", gc, 0);
        @(negedge clk);
        check("R6 control after gap", gc, 1);
        repeat (11) @(negedge clk);
        check("R6 data before gap end", gd, 0);
        @(negedge clk);
        check("R6 data after gap", gd, 1);
        check("R6 phase on", phase, 2);
        rd(2'd3, d);
        check("R5 status phase field", d[6:4], 2);
        check("R5 status start bit", d[0], 1);
        @(negedge clk);

        // R7 power-down, R8 zero delay
        wr_reg(2'd3, 32'd0);
        @(negedge clk);
        check("R7 data drops first", gd, 0);
        check("R7 control held", gc, 1);
        check("R7 phase down", phase, 3);
        repeat (7) @(negedge clk);
        check("R7 control before gap end", gc, 1);
        @(negedge clk);
        check("R7 control dropped", gc, 0);
        check("R7 supply held", gs, 1);
        repeat (3) @(negedge clk);
        check("R8 zero delay not yet over", gs, 1);
        @(negedge clk);
        check("R8 zero delay is one tick", gs, 0);
        check("R7 phase rest", phase, 4);

        // R10 start during rest waits for the gap
        cnt = 1;
        leak = 0;
        wr_reg(2'd3, 32'd1);
        if (phase == 3'd4) begin cnt++; leak |= gs; end
        for (int i = 0; i < 100 && phase == 3'd4; i++) begin
            @(negedge clk);
            if (phase == 3'd4) begin cnt++; leak |= gs; end
        end
        check("R7 rest length", cnt, 20);
        check("R10 no gate during rest", leak, 0);
        check("R10 off after rest", phase, 0);
        @(negedge clk);
        check("R10 power-up after rest", gs, 1);
        check("R10 phase up", phase, 1);

        // R9 abort with only supply on
        wr_reg(2'd3, 32'd0);
        repeat (6) @(negedge clk);
        check("R9 still ramping", phase, 1);
        @(negedge clk);
        check("R9 abort goes down", phase, 3);
        check("R9 control never rose", gc, 0);
        check("R9 supply held", gs, 1);
        repeat (3) @(negedge clk);
        check("R9 supply before drop", gs, 1);
        @(negedge clk);
        check("R9 supply dropped", gs, 0);
        for (int i = 0; i < 100 && phase != 3'd0; i++) @(negedge clk);

        // R9 abort with control on
        wr_reg(2'd3, 32'd1);
        for (int i = 0; i < 100 && !gc; i++) @(negedge clk);
        wr_reg(2'd3, 32'd0);
        repeat (10) @(negedge clk);
        check("R9 second step running", phase, 1);
        @(negedge clk);
        check("R9 abort after step", phase, 3);
        check("R9 data never rose", gd, 0);
        check("R9 control held", gc, 1);
        repeat (7) @(negedge clk);
        check("R9 control before drop", gc, 1);
        @(negedge clk);
        check("R9 control dropped", gc, 0);
        check("R9 supply still on", gs, 1);
        repeat (30) @(negedge clk);
        check("R7 back to off", phase, 0);

        finished = 1;
        summary();
    end
endmodule